// File: doc/BRIEF.md
# Fully Associative Translation Cache with Walker Refill

This block keeps recent virtual-to-physical page translations so that most memory accesses avoid a trip to the page table. Each request carries a virtual page number, the ID of the running process and a write flag. The block compares that request against every stored translation in the same cycle. On a hit it returns the frame number and protection bits one cycle later. A write that hits a clean translation marks it modified and reports that the bit has just been set, so software can bring the page table up to date.

On a miss the block sends a one-cycle request to an external page-table walker. It then accepts no new lookups until the walker answers. A good answer is written into a victim slot and returned to the requester in the following cycle. A fault answer is only passed back, and nothing is stored. Each translation is tagged with a process ID, so switching processes does not require emptying the cache. Software can still drop every translation at once, or only those of a single process.

Top module: `tlb_fa`

## Requirements
- R1: After reset no translation is valid, `req_ready` is 1, and `rsp_valid` and `walk_req_valid` are 0.
- R2: When an accepted request matches a valid translation, `rsp_valid` and `rsp_hit` are 1 in the next cycle, with that translation's frame number and protection bits.
- R3: A translation hits only for a request carrying the same process ID. The same page under another ID misses, and the two translations can coexist.
- R4: On a miss, `walk_req_valid` is 1 for exactly one cycle, the cycle after acceptance, carrying the missing page and process ID. `req_ready` stays 0 from acceptance until the response.
- R5: The response to a miss appears in the cycle after `walk_rsp_valid`, with `rsp_hit`=0 and the frame and protection supplied by the walker. The translation is stored, so the same lookup then hits.
- R6: A walker answer with `walk_rsp_fault`=1 gives a response with `rsp_fault`=1 and frame and protection equal to 0. Nothing is stored, so repeating the lookup misses again.
- R7: A write hit on a clean translation sets its modified bit and returns `rsp_dirty_set`=1. A write hit on a translation that is already modified returns 0. A write miss stores the translation as modified and returns 1.
- R8: The victim slot is the lowest-numbered invalid slot. If every slot is valid, it is the slot under a rotating pointer. The pointer is 0 after reset and advances by one, wrapping at the slot count, on every store.
- R9: `flush_all` invalidates every translation in one cycle. `flush_pid` invalidates only translations whose process ID equals `flush_pid_val`. While either input is high, `req_ready` is 0.
- R10: A request presented while `req_ready` is 0 is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_pid | input | PID_W | Process ID of the requester |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Response came from a stored translation |
| rsp_fault | output | 1 | Walker reported a fault |
| rsp_pfn | output | PFN_W | Physical frame number |
| rsp_prot | output | PROT_W | Protection bits |
| rsp_dirty_set | output | 1 | Modified bit was newly set by this write |
| walk_req_valid | output | 1 | Page-table lookup request |
| walk_vpn | output | VPN_W | Page to look up |
| walk_pid | output | PID_W | Process ID for the lookup |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_fault | input | 1 | Walker found no valid mapping |
| walk_rsp_pfn | input | PFN_W | Frame returned by walker |
| walk_rsp_prot | input | PROT_W | Protection returned by walker |
| flush_all | input | 1 | Invalidate all translations |
| flush_pid | input | 1 | Invalidate translations of one process |
| flush_pid_val | input | PID_W | Process ID selected for `flush_pid` |

## Verification
The hardest state to reach is a completely full cache, where the rotating pointer rather than the free-slot search chooses the victim. It is harder still to then open holes in it selectively. The stimulus fills all 64 slots with distinct even pages and gives a scattered subset a second process ID. It then issues further misses, so that successive evictions walk the pointer across the earliest entries. After that it flushes the second process, so the next stores must land in the lowest hole and not under the pointer. A behavioural model is compared on every clock: it tracks slots, pointer and modified bits, and checks each outcome through the hit, miss and walk ports.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,
        TS_ISSUE = 2'd1,
        TS_WAIT  = 2'd2
    } tlb_state_e;

    function automatic logic busy_state(input tlb_state_e s);
        return s != TS_IDLE;
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PID_W   = 8,
    parameter bit USE_PID = 1'b1,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic [VPN_W-1:0]   ent_vpn [ENTRIES],
    input  logic [PID_W-1:0]   ent_pid [ENTRIES],
    input  logic [VPN_W-1:0]   look_vpn,
    input  logic [PID_W-1:0]   look_pid,
    output logic [ENTRIES-1:0] hit_vec,
    output logic               hit_any,
    output logic [IDX_W-1:0]   hit_idx
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        if (USE_PID) begin : g_tagged
            assign hit_vec[g] = ent_valid[g] && (ent_vpn[g] == look_vpn)
                                && (ent_pid[g] == look_pid);
        end else begin : g_untagged
            assign hit_vec[g] = ent_valid[g] && (ent_vpn[g] == look_vpn);
        end
    end

    assign hit_any = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic               advance,
    output logic [IDX_W-1:0]   victim_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;
    logic             free_any;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign victim_idx = free_any ? free_idx : rr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (advance) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    parameter int PID_W   = 8,
    parameter int PROT_W  = 3,
    parameter bit USE_PID = 1'b1,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush_all,
    input  logic               flush_pid,
    input  logic [PID_W-1:0]   flush_pid_val,
    input  logic               set_mod,
    input  logic [IDX_W-1:0]   set_mod_idx,
    input  logic               ins,
    input  logic [IDX_W-1:0]   ins_idx,
    input  logic [VPN_W-1:0]   ins_vpn,
    input  logic [PID_W-1:0]   ins_pid,
    input  logic [PFN_W-1:0]   ins_pfn,
    input  logic [PROT_W-1:0]  ins_prot,
    input  logic               ins_mod,
    output logic [ENTRIES-1:0] ent_valid,
    output logic [ENTRIES-1:0] ent_mod,
    output logic [VPN_W-1:0]   ent_vpn  [ENTRIES],
    output logic [PID_W-1:0]   ent_pid  [ENTRIES],
    output logic [PFN_W-1:0]   ent_pfn  [ENTRIES],
    output logic [PROT_W-1:0]  ent_prot [ENTRIES]
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic              valid_q;
        logic              mod_q;
        logic [VPN_W-1:0]  vpn_q;
        logic [PID_W-1:0]  pid_q;
        logic [PFN_W-1:0]  pfn_q;
        logic [PROT_W-1:0] prot_q;
        logic              sel_ins;
        logic              sel_mod;
        logic              pid_drop;

        assign sel_ins  = ins && (ins_idx == IDX_W'(g));
        assign sel_mod  = set_mod && (set_mod_idx == IDX_W'(g));
        assign pid_drop = flush_pid && (!USE_PID || (pid_q == flush_pid_val));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= 1'b0;
                mod_q   <= 1'b0;
            end else begin
                if (flush_all || pid_drop) valid_q <= 1'b0;
                if (sel_mod)               mod_q   <= 1'b1;
                if (sel_ins) begin
                    valid_q <= 1'b1;
                    mod_q   <= ins_mod;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (sel_ins) begin
                vpn_q  <= ins_vpn;
                pid_q  <= ins_pid;
                pfn_q  <= ins_pfn;
                prot_q <= ins_prot;
            end
        end

        assign ent_valid[g] = valid_q;
        assign ent_mod[g]   = mod_q;
        assign ent_vpn[g]   = vpn_q;
        assign ent_pid[g]   = pid_q;
        assign ent_pfn[g]   = pfn_q;
        assign ent_prot[g]  = prot_q;
    end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    parameter int PID_W   = 8,
    parameter int PROT_W  = 3,
    parameter bit USE_PID = 1'b1,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [PID_W-1:0]  req_pid,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic [PROT_W-1:0] rsp_prot,
    output logic              rsp_dirty_set,
    output logic              walk_req_valid,
    output logic [VPN_W-1:0]  walk_vpn,
    output logic [PID_W-1:0]  walk_pid,
    input  logic              walk_rsp_valid,
    input  logic              walk_rsp_fault,
    input  logic [PFN_W-1:0]  walk_rsp_pfn,
    input  logic [PROT_W-1:0] walk_rsp_prot,
    input  logic              flush_all,
    input  logic              flush_pid,
    input  logic [PID_W-1:0]  flush_pid_val
);

    tlb_state_e state_q;

    logic [ENTRIES-1:0] ent_valid;
    logic [ENTRIES-1:0] ent_mod;
    logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
    logic [PID_W-1:0]   ent_pid  [ENTRIES];
    logic [PFN_W-1:0]   ent_pfn  [ENTRIES];
    logic [PROT_W-1:0]  ent_prot [ENTRIES];

    logic [ENTRIES-1:0] hit_vec;
    logic               hit_any;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   victim_idx;

    logic [VPN_W-1:0]   pend_vpn;
    logic [PID_W-1:0]   pend_pid;
    logic               pend_wr;

    logic busy;
    logic accept;
    logic lk_hit;
    logic lk_miss;
    logic refill_done;
    logic install;
    logic set_mod;

    assign busy        = busy_state(state_q);
    assign req_ready   = !busy && !flush_all && !flush_pid;
    assign accept      = req_valid && req_ready;
    assign lk_hit      = accept && hit_any;
    assign lk_miss     = accept && !hit_any;
    assign refill_done = busy && walk_rsp_valid;
    assign install     = refill_done && !walk_rsp_fault;
    assign set_mod     = lk_hit && req_write;

    tlb_match #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .USE_PID(USE_PID)
    ) u_match (
        .ent_valid (ent_valid),
        .ent_vpn   (ent_vpn),
        .ent_pid   (ent_pid),
        .look_vpn  (req_vpn),
        .look_pid  (req_pid),
        .hit_vec   (hit_vec),
        .hit_any   (hit_any),
        .hit_idx   (hit_idx)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk        (clk),
        .rst        (rst),
        .ent_valid  (ent_valid),
        .advance    (install),
        .victim_idx (victim_idx)
    );

    tlb_store #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .PID_W(PID_W),
        .PROT_W(PROT_W), .USE_PID(USE_PID)
    ) u_store (
        .clk           (clk),
        .rst           (rst),
        .flush_all     (flush_all),
        .flush_pid     (flush_pid),
        .flush_pid_val (flush_pid_val),
        .set_mod       (set_mod),
        .set_mod_idx   (hit_idx),
        .ins           (install),
        .ins_idx       (victim_idx),
        .ins_vpn       (pend_vpn),
        .ins_pid       (pend_pid),
        .ins_pfn       (walk_rsp_pfn),
        .ins_prot      (walk_rsp_prot),
        .ins_mod       (pend_wr),
        .ent_valid     (ent_valid),
        .ent_mod       (ent_mod),
        .ent_vpn       (ent_vpn),
        .ent_pid       (ent_pid),
        .ent_pfn       (ent_pfn),
        .ent_prot      (ent_prot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TS_IDLE;
        end else begin
            unique case (state_q)
                TS_IDLE:  if (lk_miss) state_q <= TS_ISSUE;
                TS_ISSUE: state_q <= walk_rsp_valid ? TS_IDLE : TS_WAIT;
                TS_WAIT:  if (walk_rsp_valid) state_q <= TS_IDLE;
                default:  state_q <= TS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vpn <= '0;
            pend_pid <= '0;
            pend_wr  <= 1'b0;
        end else if (lk_miss) begin
            pend_vpn <= req_vpn;
            pend_pid <= req_pid;
            pend_wr  <= req_write;
        end
    end

    assign walk_req_valid = (state_q == TS_ISSUE);
    assign walk_vpn       = pend_vpn;
    assign walk_pid       = pend_pid;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_fault     <= 1'b0;
            rsp_pfn       <= '0;
            rsp_prot      <= '0;
            rsp_dirty_set <= 1'b0;
        end else begin
            rsp_valid <= lk_hit || refill_done;
            if (lk_hit) begin
                rsp_hit       <= 1'b1;
                rsp_fault     <= 1'b0;
                rsp_pfn       <= ent_pfn[hit_idx];
                rsp_prot      <= ent_prot[hit_idx];
                rsp_dirty_set <= req_write && !ent_mod[hit_idx];
            end else if (refill_done) begin
                rsp_hit       <= 1'b0;
                rsp_fault     <= walk_rsp_fault;
                rsp_pfn       <= walk_rsp_fault ? '0 : walk_rsp_pfn;
                rsp_prot      <= walk_rsp_fault ? '0 : walk_rsp_prot;
                rsp_dirty_set <= pend_wr && !walk_rsp_fault;
            end
        end
    end

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
    parameter int ENTRIES = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic [ENTRIES-1:0] hit_vec,
    input logic               hit_any,
    input logic [ENTRIES-1:0] ent_valid,
    input logic               install,
    input logic               busy,
    input logic               walk_req_valid,
    input logic               walk_rsp_valid,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_fault,
    input logic               rsp_dirty_set,
    input logic               flush_all
);

    p_hit_rsp_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && hit_any) |=> (rsp_valid && rsp_hit));

    p_single_match_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    p_walk_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        walk_req_valid |=> !walk_req_valid);

    p_walk_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        walk_req_valid |-> !req_ready);

    p_refill_rsp_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && walk_rsp_valid) |=> (rsp_valid && !rsp_hit));

    p_fault_clean_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (!rsp_hit && !rsp_dirty_set));

    p_flush_gate_r9: assert property (@(posedge clk) disable iff (rst)
        flush_all |-> !req_ready);

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (flush_all && !install) |=> (ent_valid == '0));

    p_busy_gate_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ready);

endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .hit_vec        (hit_vec),
    .hit_any        (hit_any),
    .ent_valid      (ent_valid),
    .install        (install),
    .busy           (busy),
    .walk_req_valid (walk_req_valid),
    .walk_rsp_valid (walk_rsp_valid),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_fault      (rsp_fault),
    .rsp_dirty_set  (rsp_dirty_set),
    .flush_all      (flush_all)
);

// File: tb/tlb_fa_tb.sv
`timescale 1ns/1ps
module tlb_fa_tb;

    localparam int N      = 64;
    localparam int VPN_W  = 20;
    localparam int PFN_W  = 16;
    localparam int PID_W  = 8;
    localparam int PROT_W = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [VPN_W-1:0]  req_vpn = '0;
    logic [PID_W-1:0]  req_pid = '0;
    logic              req_write = 1'b0;
    logic              rsp_valid, rsp_hit, rsp_fault, rsp_dirty_set;
    logic [PFN_W-1:0]  rsp_pfn;
    logic [PROT_W-1:0] rsp_prot;
    logic              walk_req_valid;
    logic [VPN_W-1:0]  walk_vpn;
    logic [PID_W-1:0]  walk_pid;
    logic              walk_rsp_valid = 1'b0;
    logic              walk_rsp_fault = 1'b0;
    logic [PFN_W-1:0]  walk_rsp_pfn = '0;
    logic [PROT_W-1:0] walk_rsp_prot = '0;
    logic              flush_all = 1'b0;
    logic              flush_pid = 1'b0;
    logic [PID_W-1:0]  flush_pid_val = '0;

    always #4 clk = ~clk;

    tlb_fa u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
        .req_pid(req_pid), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_pfn(rsp_pfn), .rsp_prot(rsp_prot), .rsp_dirty_set(rsp_dirty_set),
        .walk_req_valid(walk_req_valid), .walk_vpn(walk_vpn), .walk_pid(walk_pid),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_fault(walk_rsp_fault),
        .walk_rsp_pfn(walk_rsp_pfn), .walk_rsp_prot(walk_rsp_prot),
        .flush_all(flush_all), .flush_pid(flush_pid), .flush_pid_val(flush_pid_val)
    );

    int    checks = 0;
    int    fails  = 0;
    string phase  = "R1";

    // behavioural reference state
    bit  m_v   [N];
    bit  m_mod [N];
    int  m_vpn [N];
    int  m_pid [N];
    int  m_pfn [N];
    int  m_prot[N];
    int  m_rr;
    bit  pend;
    int  p_vpn, p_pid;
    bit  p_wr;
    bit  e_rv, e_hit, e_fault, e_dirty, e_walk;
    int  e_pfn, e_prot, e_wvpn, e_wpid;
    int  h, vi;
    bit  rdy;

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", phase, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin m_v[i] = 0; m_mod[i] = 0; end
            m_rr = 0; pend = 0; e_rv = 0; e_walk = 0;
        end else begin
            rdy = !pend && !flush_all && !flush_pid;
            e_rv = 0; e_walk = 0; vi = -1;
            if (rdy && req_valid) begin
                h = -1;
                for (int i = 0; i < N; i++)
                    if (m_v[i] && m_vpn[i] == int'(req_vpn) && m_pid[i] == int'(req_pid)) h = i;
                if (h >= 0) begin
                    e_rv = 1; e_hit = 1; e_fault = 0;
                    e_pfn = m_pfn[h]; e_prot = m_prot[h];
                    e_dirty = req_write && !m_mod[h];
                    if (req_write) m_mod[h] = 1;
                end else begin
                    pend = 1; p_vpn = int'(req_vpn); p_pid = int'(req_pid); p_wr = req_write;
                    e_walk = 1; e_wvpn = p_vpn; e_wpid = p_pid;
                end
            end else if (pend && walk_rsp_valid) begin
                pend = 0; e_rv = 1; e_hit = 0; e_fault = walk_rsp_fault;
                e_pfn   = walk_rsp_fault ? 0 : int'(walk_rsp_pfn);
                e_prot  = walk_rsp_fault ? 0 : int'(walk_rsp_prot);
                e_dirty = p_wr && !walk_rsp_fault;
                if (!walk_rsp_fault) begin
                    for (int i = 0; i < N; i++) if (!m_v[i] && vi < 0) vi = i;
                    if (vi < 0) vi = m_rr;
                    m_rr = (m_rr + 1) % N;
                end
            end
            if (flush_all) for (int i = 0; i < N; i++) m_v[i] = 0;
            if (flush_pid) for (int i = 0; i < N; i++)
                if (m_pid[i] == int'(flush_pid_val)) m_v[i] = 0;
            if (vi >= 0) begin
                m_v[vi] = 1; m_mod[vi] = p_wr; m_vpn[vi] = p_vpn; m_pid[vi] = p_pid;
                m_pfn[vi] = e_pfn; m_prot[vi] = e_prot;
            end
        end
    end

    // per-cycle comparison, away from the clock edge
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            check("req_ready", int'(req_ready), int'(!pend && !flush_all && !flush_pid));
            check("rsp_valid", int'(rsp_valid), int'(e_rv));
            if (e_rv) begin
                check("rsp_hit", int'(rsp_hit), int'(e_hit));
                check("rsp_fault", int'(rsp_fault), int'(e_fault));
                check("rsp_pfn", int'(rsp_pfn), e_pfn);
                check("rsp_prot", int'(rsp_prot), e_prot);
                check("rsp_dirty_set", int'(rsp_dirty_set), int'(e_dirty));
            end
            check("walk_req_valid", int'(walk_req_valid), int'(e_walk));
            if (e_walk) begin
                check("walk_vpn", int'(walk_vpn), e_wvpn);
                check("walk_pid", int'(walk_pid), e_wpid);
            end
        end
    end

    // page-table walker model
    int lat = 1;
    bit w_on = 0;
    int w_cnt, w_vpn, w_pid;
    always @(negedge clk) begin
        walk_rsp_valid = 1'b0;
        if (!w_on && walk_req_valid) begin
            w_on = 1; w_cnt = lat; w_vpn = int'(walk_vpn); w_pid = int'(walk_pid);
        end
        if (w_on) begin
            if (w_cnt == 0) begin
                walk_rsp_valid = 1'b1;
                walk_rsp_fault = (w_vpn % 16) == 15;
                walk_rsp_pfn   = PFN_W'(w_vpn * 37 + w_pid * 101);
                walk_rsp_prot  = PROT_W'(w_vpn + w_pid);
                w_on = 0;
            end else begin
                w_cnt--;
            end
        end
    end

    task automatic lookup(input int vpn, input int pid, input bit wr);
        @(negedge clk);
        req_valid = 1'b1; req_vpn = VPN_W'(vpn); req_pid = PID_W'(pid); req_write = wr;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        while (pend) @(negedge clk);
    endtask

    task automatic stray_during_miss(input int vpn, input int pid);
        @(negedge clk);
        req_valid = 1'b1; req_vpn = VPN_W'(vpn); req_pid = PID_W'(pid);
        @(negedge clk);
        req_vpn = VPN_W'('h010); req_pid = PID_W'(1);   // would hit if accepted
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (pend) @(negedge clk);
    endtask

    task automatic do_flush_all();
        @(negedge clk); flush_all = 1'b1;
        @(negedge clk); flush_all = 1'b0;
    endtask

    task automatic do_flush_pid(input int pid);
        @(negedge clk); flush_pid = 1'b1; flush_pid_val = PID_W'(pid);
        @(negedge clk); flush_pid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired in phase %s", phase);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        phase = "R1";
        repeat (2) @(negedge clk);

        phase = "R4"; lat = 2;
        lookup('h010, 1, 0);
        phase = "R5";
        lookup('h010, 1, 0);
        lat = 0;
        lookup('h012, 1, 0);
        phase = "R2";
        lookup('h012, 1, 0);
        lookup('h010, 1, 0);

        phase = "R3"; lat = 1;
        lookup('h010, 2, 0);
        lookup('h010, 1, 0);
        lookup('h010, 2, 0);

        phase = "R7";
        lookup('h010, 1, 1);
        lookup('h010, 1, 1);
        lookup('h020, 1, 1);
        lookup('h020, 1, 1);
        lookup('h020, 1, 0);

        phase = "R6";
        lookup('h01F, 1, 0);
        lookup('h01F, 1, 0);
        lookup('h01F, 1, 1);

        phase = "R10"; lat = 4;
        stray_during_miss('h040, 3);
        lookup('h040, 3, 0);

        phase = "R9"; lat = 1;
        do_flush_pid(2);
        lookup('h010, 1, 0);
        lookup('h010, 2, 0);
        do_flush_all();
        lookup('h010, 1, 0);
        lookup('h020, 1, 0);

        phase = "R8";
        do_flush_all();
        for (int i = 0; i < N; i++)
            lookup('h100 + 2 * i, ((i % 16) == 5) ? 2 : 1, 0);
        lookup('h900, 1, 0);
        lookup('h102, 1, 0);
        lookup('h100, 1, 0);
        lookup('h102, 1, 0);
        lookup('h104, 1, 0);
        do_flush_pid(2);
        lookup('hA00, 1, 0);
        lookup('hA02, 1, 0);
        lookup('h10A, 2, 0);
        lookup('hA00, 1, 0);
        for (int i = 0; i < 6; i++) lookup('hB00 + 2 * i, 1, 0);
        lookup('h108, 1, 0);

        phase = "R2";
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule